// File: doc/BRIEF.md
# Memory-to-Memory Copy Engine

The block is a single-channel copy engine. Software loads a three-word channel descriptor into a small internal table: the last source address, the last destination address and a packed control word. A software request then starts the channel, provided the channel is enabled, its request mask is clear and the control word selects auto-request mode. In that mode the engine reads one item, writes it, and repeats until every item has moved. No further request is needed once the copy has started.

Each item's address is found by counting back from the inclusive end pointer. The distance back is the number of items still to move, scaled by that side's increment. An increment code of 3 holds the address fixed. After every 2^A items, where A is the arbitration exponent, the engine gives up the memory port for one idle cycle before it issues the next read. When the last write completes, the engine clears the channel enable, writes the mode field back to stopped and pulses `done`.

Top module: `dmae_engine`

## Requirements
- R1: After reset: `busy`, `done`, `mem_req`, `chan_en`, `chan_mask` and `chan_burst` are 0, and all three table words read back as 0.
- R2: Table index 0 holds the source end pointer, index 1 the destination end pointer and index 2 the control word; `cfg_rdata` returns the addressed word in the same cycle, and index 3 reads 0. Control word fields: destination increment [31:30], destination size [29:28], source increment [27:26], source size [25:24], arbitration exponent [17:14], item count minus one [13:4], mode [2:0].
- R3: A one-cycle `sw_req` starts a copy only when the engine is idle, `chan_en` is 1, `chan_mask` is 0 and the mode field is 2. In every other case the request is dropped and `mem_req` stays low.
- R4: A copy moves count field + 1 items. Each item is one read followed by one write of the data just read.
- R5: For item k of N (k counting from 0), the address on each side is end pointer − ((N−1−k) << inc), where inc is that side's increment code 0, 1 or 2. Increment code 3 keeps the address at the end pointer.
- R6: `mem_size` carries the source size code during reads and the destination size code during writes.
- R7: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values.
- R8: After every 2^A completed items, except after the last item, `mem_req` is low for exactly one cycle while `busy` stays high, and a read follows. A copy of N items therefore has (N−1)>>A idle cycles.
- R9: In the cycle after the final write handshake, `done` is high for exactly one cycle, `busy` and `chan_en` are 0, and the control word reads back with its mode field set to 0 and all other bits unchanged.
- R10: Table writes made while `busy` is high are ignored.
- R11: The `*_set` and `*_clr` pulses set and clear the enable, mask and burst bits; when both arrive in the same cycle, the clear wins. The burst bit does not block software requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 2 | Table word index |
| cfg_wdata | input | 32 | Table write data |
| cfg_rdata | output | 32 | Table read data for `cfg_idx` |
| en_set | input | 1 | Set channel enable |
| en_clr | input | 1 | Clear channel enable |
| mask_set | input | 1 | Set request mask |
| mask_clr | input | 1 | Clear request mask |
| burst_set | input | 1 | Set burst-only bit |
| burst_clr | input | 1 | Clear burst-only bit |
| sw_req | input | 1 | Software request pulse |
| chan_en | output | 1 | Channel enable state |
| chan_mask | output | 1 | Request mask state |
| chan_burst | output | 1 | Burst-only bit state |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Completes the current request |

## Verification
The bench builds the engine with its default 32-bit address and data widths. This lets descriptors use real byte addresses with word, halfword and byte increments. The runs cover arbitration exponents 0, 1 and 3 against item counts of 1, 4, 5 and 8. Together these give copies with an idle gap after every item, gaps at regular points, and no gap at all. The bench stalls `mem_ready` by a varying number of cycles, so request holding is exercised throughout every copy.

// File: rtl/dmae_pkg.sv
package dmae_pkg;
    localparam int WORD_W   = 32;
    localparam int CNT_W    = 10;
    localparam int ARB_W    = 4;
    localparam logic [2:0] MODE_STOP = 3'd0;
    localparam logic [2:0] MODE_AUTO = 3'd2;
    localparam logic [1:0] INC_NONE  = 2'd3;

    typedef struct packed {
        logic [1:0]       dinc;
        logic [1:0]       dsz;
        logic [1:0]       sinc;
        logic [1:0]       ssz;
        logic [5:0]       rsvd;
        logic [ARB_W-1:0] arb;
        logic [CNT_W-1:0] cnt;
        logic             nxt_burst;
        logic [2:0]       mode;
    } ctrl_t;

    typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_GAP} fsm_e;
endpackage

// File: rtl/dmae_table.sv
module dmae_table
    import dmae_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_idx,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_rdata,
    input  logic              lock,
    input  logic              fin,
    input  logic              en_set,
    input  logic              en_clr,
    input  logic              mask_set,
    input  logic              mask_clr,
    input  logic              burst_set,
    input  logic              burst_clr,
    output logic [WORD_W-1:0] src_end,
    output logic [WORD_W-1:0] dst_end,
    output ctrl_t             ctrl,
    output logic              en,
    output logic              mask,
    output logic              burst
);
    typedef struct packed {
        logic [WORD_W-1:0] src;
        logic [WORD_W-1:0] dst;
        ctrl_t             ctl;
        logic              en;
        logic              mask;
        logic              burst;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (cfg_we && !lock) begin
            case (cfg_idx)
                2'd0:    tbl_d.src = cfg_wdata;
                2'd1:    tbl_d.dst = cfg_wdata;
                2'd2:    tbl_d.ctl = ctrl_t'(cfg_wdata);
                default: ;
            endcase
        end
        if (en_set)    tbl_d.en    = 1'b1;
        if (en_clr)    tbl_d.en    = 1'b0;
        if (mask_set)  tbl_d.mask  = 1'b1;
        if (mask_clr)  tbl_d.mask  = 1'b0;
        if (burst_set) tbl_d.burst = 1'b1;
        if (burst_clr) tbl_d.burst = 1'b0;
        if (fin) begin
            tbl_d.en       = 1'b0;
            tbl_d.ctl.mode = MODE_STOP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    always_comb begin
        case (cfg_idx)
            2'd0:    cfg_rdata = tbl_q.src;
            2'd1:    cfg_rdata = tbl_q.dst;
            2'd2:    cfg_rdata = WORD_W'(tbl_q.ctl);
            default: cfg_rdata = '0;
        endcase
    end

    assign src_end = tbl_q.src;
    assign dst_end = tbl_q.dst;
    assign ctrl    = tbl_q.ctl;
    assign en      = tbl_q.en;
    assign mask    = tbl_q.mask;
    assign burst   = tbl_q.burst;
endmodule

// File: rtl/dmae_addr.sv
module dmae_addr
    import dmae_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] end_ptr,
    input  logic [1:0]        inc,
    input  logic [CNT_W-1:0]  remain,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        if (inc == INC_NONE) addr = end_ptr;
        else                 addr = end_ptr - (ADDR_W'(remain) << inc);
    end
endmodule

// File: rtl/dmae_engine.sv
module dmae_engine
    import dmae_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_idx,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              en_set,
    input  logic              en_clr,
    input  logic              mask_set,
    input  logic              mask_clr,
    input  logic              burst_set,
    input  logic              burst_clr,
    input  logic              sw_req,
    output logic              chan_en,
    output logic              chan_mask,
    output logic              chan_burst,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready
);
    typedef struct packed {
        fsm_e              st;
        logic [CNT_W-1:0]  remain;
        logic [CNT_W-1:0]  moved;
        logic [DATA_W-1:0] data;
        logic              done;
    } eng_t;

    eng_t eng_d, eng_q;

    logic [WORD_W-1:0] src_end, dst_end;
    ctrl_t             ctrl;
    logic              fin;
    logic [ADDR_W-1:0] src_addr, dst_addr;
    logic [31:0]       moved_nxt, arb_low;

    dmae_table u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .lock      (busy),
        .fin       (fin),
        .en_set    (en_set),
        .en_clr    (en_clr),
        .mask_set  (mask_set),
        .mask_clr  (mask_clr),
        .burst_set (burst_set),
        .burst_clr (burst_clr),
        .src_end   (src_end),
        .dst_end   (dst_end),
        .ctrl      (ctrl),
        .en        (chan_en),
        .mask      (chan_mask),
        .burst     (chan_burst)
    );

    dmae_addr #(.ADDR_W(ADDR_W)) u_src_addr (
        .end_ptr (src_end[ADDR_W-1:0]),
        .inc     (ctrl.sinc),
        .remain  (eng_q.remain),
        .addr    (src_addr)
    );

    dmae_addr #(.ADDR_W(ADDR_W)) u_dst_addr (
        .end_ptr (dst_end[ADDR_W-1:0]),
        .inc     (ctrl.dinc),
        .remain  (eng_q.remain),
        .addr    (dst_addr)
    );

    assign moved_nxt = 32'(eng_q.moved) + 32'd1;
    assign arb_low   = (32'd1 << ctrl.arb) - 32'd1;
    assign fin       = (eng_q.st == S_WR) && mem_ready && (eng_q.remain == '0);

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        unique case (eng_q.st)
            S_IDLE: begin
                if (sw_req && chan_en && !chan_mask && ctrl.mode == MODE_AUTO) begin
                    eng_d.st     = S_RD;
                    eng_d.remain = ctrl.cnt;
                    eng_d.moved  = '0;
                end
            end
            S_RD: begin
                if (mem_ready) begin
                    eng_d.data = mem_rdata;
                    eng_d.st   = S_WR;
                end
            end
            S_WR: begin
                if (mem_ready) begin
                    if (eng_q.remain == '0) begin
                        eng_d.st   = S_IDLE;
                        eng_d.done = 1'b1;
                    end else begin
                        eng_d.remain = eng_q.remain - 1'b1;
                        eng_d.moved  = eng_q.moved + 1'b1;
                        eng_d.st     = ((moved_nxt & arb_low) == 32'd0) ? S_GAP : S_RD;
                    end
                end
            end
            S_GAP:   eng_d.st = S_RD;
            default: eng_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eng_q <= '{st: S_IDLE, default: '0};
        else        eng_q <= eng_d;
    end

    assign busy      = (eng_q.st != S_IDLE);
    assign done      = eng_q.done;
    assign mem_req   = (eng_q.st == S_RD) || (eng_q.st == S_WR);
    assign mem_we    = (eng_q.st == S_WR);
    assign mem_addr  = mem_we ? dst_addr : src_addr;
    assign mem_size  = mem_we ? ctrl.dsz : ctrl.ssz;
    assign mem_wdata = eng_q.data;
endmodule

// File: rtl/dmae_chk.sv
module dmae_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_req,
    input logic              chan_en,
    input logic              chan_mask,
    input logic              busy,
    input logic              done,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ready
);
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

    assert_start_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(sw_req && chan_en && !chan_mask));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !chan_en);

    assert_gap_then_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !mem_req |=> mem_req && !mem_we);
endmodule

bind dmae_engine dmae_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_req    (sw_req),
    .chan_en   (chan_en),
    .chan_mask (chan_mask),
    .busy      (busy),
    .done      (done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready)
);

// File: tb/dmae_engine_tb.sv
module dmae_engine_tb;
    logic        clk = 0, rst_n = 0;
    logic        cfg_we = 0;
    logic [1:0]  cfg_idx = 0;
    logic [31:0] cfg_wdata = 0, cfg_rdata;
    logic        en_set = 0, en_clr = 0, mask_set = 0, mask_clr = 0;
    logic        burst_set = 0, burst_clr = 0, sw_req = 0;
    logic        chan_en, chan_mask, chan_burst, busy, done;
    logic        mem_req, mem_we, mem_ready = 0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
    logic [1:0]  mem_size;

    int n_chk = 0, n_fail = 0, gaps = 0, dones = 0, reqs = 0, reads = 0, wt = 0;
    logic [7:0]  lfsr = 8'h5B;
    logic [1:0]  exp_ssz = 0, exp_dsz = 0;
    logic [63:0] sb[$];
    bit          ended = 0;

    always #5 clk = ~clk;

    dmae_engine u_dut (.*);

    function automatic logic [31:0] mem_val(input logic [31:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction

    function automatic logic [31:0] mk(input int dinc, dsz, sinc, ssz, arb, cnt, mode);
        return (32'(dinc) << 30) | (32'(dsz) << 28) | (32'(sinc) << 26) | (32'(ssz) << 24)
             | (32'(arb) << 14) | (32'(cnt) << 4) | 32'(mode);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_test();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // memory model and scoreboard monitor
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ready = 0; wt = 0;
        end else begin
            if (busy && !mem_req) gaps++;
            if (done) dones++;
            if (mem_req) reqs++;
            if (mem_req && wt == 0) begin
                mem_ready = 1;
                if (mem_we) begin
                    if (sb.size() == 0) chk(0, "R4 unexpected write", {32'd0, mem_addr}, 0);
                    else begin
                        logic [63:0] e;
                        e = sb.pop_front();
                        chk({mem_addr, mem_wdata} == e, "R5 write addr/data", {mem_addr, mem_wdata}, e);
                    end
                    chk(mem_size == exp_dsz, "R6 write size", 64'(mem_size), 64'(exp_dsz));
                end else begin
                    reads++;
                    mem_rdata = mem_val(mem_addr);
                    chk(mem_size == exp_ssz, "R6 read size", 64'(mem_size), 64'(exp_ssz));
                end
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                wt = int'(lfsr % 3);
            end else begin
                mem_ready = 0;
                if (mem_req && wt > 0) wt--;
            end
        end
    end

    initial begin
        #2_000_000;
        chk(0, "watchdog expired", 0, 1);
        finish_test();
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int idx, input logic [31:0] v);
        cfg_we = 1; cfg_idx = 2'(idx); cfg_wdata = v;
        cyc(1);
        cfg_we = 0;
    endtask

    task automatic rd_chk(input int idx, input logic [31:0] e, input string tag);
        cfg_idx = 2'(idx);
        #1;
        chk(cfg_rdata == e, tag, 64'(cfg_rdata), 64'(e));
    endtask

    task automatic blocked(input string tag);
        int r0;
        r0 = reqs;
        sw_req = 1; cyc(1); sw_req = 0;
        cyc(5);
        chk(!busy && reqs == r0, tag, 64'(reqs - r0), 0);
    endtask

    // driver: loads descriptor, pushes expectations, starts, checks completion
    task automatic run(input logic [31:0] s, d, input int dinc, dsz, sinc, ssz, arb, n, input bit poke);
        logic [31:0] c;
        int g0, d0, r0, t;
        c = mk(dinc, dsz, sinc, ssz, arb, n - 1, 2);
        wr(0, s); wr(1, d); wr(2, c);
        exp_ssz = 2'(ssz); exp_dsz = 2'(dsz);
        for (int k = 0; k < n; k++) begin
            logic [31:0] sa, da;
            int rem;
            rem = n - 1 - k;
            sa = (sinc == 3) ? s : s - (32'(rem) << sinc);
            da = (dinc == 3) ? d : d - (32'(rem) << dinc);
            sb.push_back({da, mem_val(sa)});
        end
        en_set = 1; cyc(1); en_set = 0;
        g0 = gaps; d0 = dones; r0 = reads;
        sw_req = 1; cyc(1); sw_req = 0;
        if (poke) begin
            chk(busy == 1, "R3 started", 64'(busy), 1);
            wr(0, 32'hDEAD_BEEF);
        end
        t = 0;
        while (!done && t < 20000) begin cyc(1); t++; end
        chk(done == 1, "R9 done seen", 64'(done), 1);
        chk(!busy && !chan_en, "R9 idle and disabled", {busy, chan_en}, 0);
        cyc(1);
        chk(done == 0, "R9 done one cycle", 64'(done), 0);
        chk(dones - d0 == 1, "R9 pulse count", 64'(dones - d0), 1);
        chk(reads - r0 == n, "R4 item count", 64'(reads - r0), 64'(n));
        chk(sb.size() == 0, "R4 all writes seen", 64'(sb.size()), 0);
        chk(gaps - g0 == ((n - 1) >> arb), "R8 idle gaps", 64'(gaps - g0), 64'((n - 1) >> arb));
        rd_chk(2, c & ~32'h7, "R9 mode written back");
        rd_chk(0, s, "R10 source pointer kept");
    endtask

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(1);
        chk({busy, done, mem_req, chan_en, chan_mask, chan_burst} == 0, "R1 reset outputs",
            {busy, done, mem_req, chan_en, chan_mask, chan_burst}, 0);
        for (int i = 0; i < 4; i++) rd_chk(i, 0, "R1 table cleared");

        wr(0, 32'h0000_1111); wr(1, 32'h0000_2222); wr(2, mk(1, 2, 3, 0, 5, 77, 2));
        rd_chk(0, 32'h0000_1111, "R2 src word");
        rd_chk(1, 32'h0000_2222, "R2 dst word");
        rd_chk(2, mk(1, 2, 3, 0, 5, 77, 2), "R2 ctrl word");
        rd_chk(3, 0, "R2 index 3 zero");

        // R11 set/clear
        en_set = 1; en_clr = 1; cyc(1); en_set = 0; en_clr = 0;
        chk(chan_en == 0, "R11 clear wins", 64'(chan_en), 0);
        mask_set = 1; cyc(1); mask_set = 0;
        chk(chan_mask == 1, "R11 mask set", 64'(chan_mask), 1);
        burst_set = 1; cyc(1); burst_set = 0;
        chk(chan_burst == 1, "R11 burst set", 64'(chan_burst), 1);

        // R3 blocked starts
        blocked("R3 disabled ignored");
        en_set = 1; cyc(1); en_set = 0;
        blocked("R3 masked ignored");
        mask_clr = 1; cyc(1); mask_clr = 0;
        chk(chan_mask == 0, "R11 mask clear", 64'(chan_mask), 0);
        wr(2, mk(2, 2, 2, 2, 1, 3, 0));
        blocked("R3 stopped mode ignored");

        // R11 burst bit set does not block software request
        run(32'h0000_5006, 32'h0000_6006, 1, 1, 1, 1, 0, 4, 0);
        burst_clr = 1; cyc(1); burst_clr = 0;
        chk(chan_burst == 0, "R11 burst clear", 64'(chan_burst), 0);

        // R4 R5 R8 word copy with gaps every 2 items
        run(32'h0000_101C, 32'h0000_201C, 2, 2, 2, 2, 1, 8, 0);
        // R5 fixed source, byte destination, no gaps; R10 write while busy
        run(32'h0000_3000, 32'h0000_4004, 0, 0, 3, 2, 3, 5, 1);
        // single item
        run(32'h0000_7000, 32'h0000_8000, 2, 2, 2, 2, 0, 1, 0);

        blocked("R3 after completion mode is stopped");
        finish_test();
    end
endmodule